// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block converts word-oriented requests of 1 to 16  32-bit words into a series of access cycles on an 8-bit or 16-bit asynchronous external memory bus. A requester hands over a request with a valid/ready handshake. The block then runs one external access for each bus-width slice of the request. Each access has a setup phase, a strobe phase and a hold phase, and the length of each phase comes from its own 4-bit timing input.

A turnaround gap of programmable length comes before the first access of any request whose direction differs from the previous request. An external wait input can stretch the strobe phase, but only up to a programmed number of extra cycles. When that cap is hit, the access is closed anyway and a sticky timeout flag is raised. Write words are pulled from the requester one at a time. Read words are assembled little-endian and handed back as single-cycle pulses.

A cycle counter reports how long the current request has been running, and it keeps its final value once the request is done. This lets system logic confirm that a request stays within the cycle budget set by a shared SDRAM's row-active and refresh limits.

Top module: `async_mem_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `mem_cs_o`, `mem_oe_o`, `mem_we_o`, `rvalid_o` and `timeout_o` are 0, and `acc_cycles_o` is 0.
- R2: A request is taken only in a cycle where `req_ready_o` and `req_valid_i` are both high. `req_ready_o` is low from the cycle after acceptance through the last hold cycle of the final access, and it returns high in the next cycle.
- R3: A request of W words (`req_words_i` = W-1) produces exactly W*4/B accesses, where B is the bus width in bytes. The access byte addresses start at 4*`req_waddr_i` and step by B.
- R4: Each access drives `mem_cs_o` high for (S+1) setup cycles, then (T+1) strobe cycles, then (H+1) hold cycles, where S, T and H are the timing inputs. `mem_oe_o` (read) or `mem_we_o` (write) is high only during strobe. Consecutive accesses of one request follow each other with no gap.
- R5: Before the first access of a request whose direction differs from the previous request, there are (U+1) turnaround cycles with `mem_cs_o` low. When the direction matches, there are none. After reset the previous direction is taken to be read.
- R6: If `mem_wait_i` is high on the last nominal strobe cycle, the strobe is extended one cycle at a time while wait stays high. The extension is at most M cycles, where M is `cfg_wait_max_i`.
- R7: If the strobe ends at the M-cycle cap while `mem_wait_i` is still high, `timeout_o` is set. It stays set until the next request is accepted, and acceptance clears it.
- R8: Read data is sampled on the last strobe cycle and placed little-endian, with the lowest address in bits [7:0]. When a word's final slice has been captured, the word appears on `rdata_o` with a one-cycle `rvalid_o` pulse.
- R9: `wdata_pop_o` pulses once per write word, in the cycle the word's first access begins. The word on `wdata_i` in that cycle is written out lowest byte first. Address and write data stay stable through strobe and hold.
- R10: `acc_cycles_o` is cleared on acceptance, counts every busy cycle including turnaround, and holds the request's total once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request may be taken |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_waddr_i | input | ADDR_W-2 | Word address of first word |
| req_words_i | input | 4 | Word count minus one |
| cfg_setup_i | input | TW | Setup length minus one |
| cfg_strobe_i | input | TW | Strobe length minus one |
| cfg_hold_i | input | TW | Hold length minus one |
| cfg_turn_i | input | TW | Turnaround length minus one |
| cfg_wait_max_i | input | WW | Maximum strobe extension in cycles |
| wdata_i | input | 32 | Current write word |
| wdata_pop_o | output | 1 | Write word consumed this cycle |
| rdata_o | output | 32 | Assembled read word |
| rvalid_o | output | 1 | Read word valid pulse |
| mem_addr_o | output | ADDR_W | External byte address |
| mem_cs_o | output | 1 | External chip select |
| mem_oe_o | output | 1 | External read strobe |
| mem_we_o | output | 1 | External write strobe |
| mem_dout_o | output | BUS_W | External write data |
| mem_din_i | input | BUS_W | External read data |
| mem_wait_i | input | 1 | External wait request |
| timeout_o | output | 1 | Sticky wait-cap timeout for current request |
| acc_cycles_o | output | CNT_W | Busy cycles of the current request |

## Verification
The bench builds two instances side by side, one with BUS_W=8 and one with BUS_W=16, both with a 10-bit byte address and the default 4-bit timing and 8-bit wait fields. The 8-bit instance reaches the 64-access request, the four-slice byte assembly and minimum one-cycle phases. The 16-bit instance covers halfword splitting, strobe stretching both below and at the wait cap, and the sticky timeout. Running alternating read and write requests on each instance covers the case where a turnaround is inserted as well as the case where it is skipped.

// File: rtl/asq_pkg.sv
`timescale 1ns/1ps
package asq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/asq_phase_timer.sv
`timescale 1ns/1ps
module asq_phase_timer #(
  parameter int TW = 4,
  parameter int WW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  input  logic          strobe_i,
  input  logic          wait_i,
  input  logic [WW-1:0] wait_max_i,
  output logic          last_o,
  output logic          cap_o
);
  logic [TW-1:0] cnt_q;
  logic [WW-1:0] ext_q;
  logic          at_end, stretch;

  assign at_end  = (cnt_q == '0);
  assign stretch = strobe_i && at_end && wait_i && (ext_q != wait_max_i);
  assign last_o  = at_end && !stretch;
  assign cap_o   = strobe_i && at_end && wait_i && (ext_q == wait_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
      ext_q <= '0;
    end else if (!at_end) begin
      cnt_q <= cnt_q - TW'(1);
    end else if (stretch) begin
      ext_q <= ext_q + WW'(1);
    end
  end

  // R6: extension never passes the programmed cap
  a_r6_ext_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (ext_q <= wait_max_i));
endmodule

// File: rtl/asq_lane_path.sv
`timescale 1ns/1ps
module asq_lane_path #(
  parameter int BUS_W  = 16,
  parameter int LANE_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wload_i,
  input  logic [31:0]       wdata_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [BUS_W-1:0]  dout_o,
  input  logic              cap_i,
  input  logic [BUS_W-1:0]  din_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int LANES = 32 / BUS_W;

  logic [31:0] wbuf_q, rbuf_q, rnext;

  assign dout_o = wbuf_q[lane_i*BUS_W +: BUS_W];

  always_comb begin
    rnext = rbuf_q;
    rnext[lane_i*BUS_W +: BUS_W] = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q   <= '0;
      rbuf_q   <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      if (wload_i) wbuf_q <= wdata_i;
      if (cap_i) begin
        rbuf_q <= rnext;
        if (lane_i == LANE_W'(LANES - 1)) begin
          rdata_o  <= rnext;
          rvalid_o <= 1'b1;
        end
      end
    end
  end

  // R8: a read word only follows a strobe capture, and pulses for one cycle
  a_r8_word_after_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cap_i));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/async_mem_seq.sv
`timescale 1ns/1ps
module async_mem_seq
  import asq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  parameter int TW     = 4,
  parameter int WW     = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-3:0] req_waddr_i,
  input  logic [3:0]        req_words_i,
  input  logic [TW-1:0]     cfg_setup_i,
  input  logic [TW-1:0]     cfg_strobe_i,
  input  logic [TW-1:0]     cfg_hold_i,
  input  logic [TW-1:0]     cfg_turn_i,
  input  logic [WW-1:0]     cfg_wait_max_i,
  input  logic [31:0]       wdata_i,
  output logic              wdata_pop_o,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_o,
  output logic              mem_oe_o,
  output logic              mem_we_o,
  output logic [BUS_W-1:0]  mem_dout_o,
  input  logic [BUS_W-1:0]  mem_din_i,
  input  logic              mem_wait_i,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  acc_cycles_o
);
  localparam int BYTES   = BUS_W / 8;
  localparam int LANES   = 32 / BUS_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int BEAT_W  = 4 + LANE_W;
  localparam int AOFF    = $clog2(BYTES);
  localparam int MAX_CYC = LANES * 16 * (3 * (2 ** TW) + (2 ** WW) - 1) + (2 ** TW);

  seq_state_e              state_q, state_d;
  logic                    wr_q, to_q, accept, load, last, cap, wr_now, cap_rd;
  logic [ADDR_W-3:0]       base_q;
  logic [BEAT_W-1:0]       beat_q, last_q, next_beat;
  logic [TW-1:0]           len;
  logic [CNT_W-1:0]        cyc_q;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    len     = cfg_setup_i;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        load = 1'b1;
        if (req_write_i != wr_q) begin
          state_d = ST_TURN;
          len     = cfg_turn_i;
        end else begin
          state_d = ST_SETUP;
        end
      end
      ST_TURN: if (last) begin
        state_d = ST_SETUP;
        load    = 1'b1;
      end
      ST_SETUP: if (last) begin
        state_d = ST_STROBE;
        load    = 1'b1;
        len     = cfg_strobe_i;
      end
      ST_STROBE: if (last) begin
        state_d = ST_HOLD;
        load    = 1'b1;
        len     = cfg_hold_i;
      end
      ST_HOLD: if (last) begin
        load    = 1'b1;
        state_d = (beat_q == last_q) ? ST_IDLE : ST_SETUP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign next_beat   = (state_q == ST_HOLD) ? beat_q + BEAT_W'(1) :
                       (state_q == ST_IDLE) ? '0 : beat_q;
  assign wr_now      = (state_q == ST_IDLE) ? req_write_i : wr_q;
  assign wdata_pop_o = load && (state_d == ST_SETUP) && wr_now &&
                       (next_beat[LANE_W-1:0] == '0);
  assign cap_rd      = (state_q == ST_STROBE) && last && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      to_q    <= 1'b0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q   <= req_write_i;
        base_q <= req_waddr_i;
        beat_q <= '0;
        last_q <= {req_words_i, {LANE_W{1'b1}}};
        to_q   <= 1'b0;
        cyc_q  <= '0;
      end else begin
        if (state_q != ST_IDLE) cyc_q <= cyc_q + CNT_W'(1);
        if (state_q == ST_HOLD && last && beat_q != last_q) beat_q <= beat_q + BEAT_W'(1);
        if (cap) to_q <= 1'b1;
      end
    end
  end

  asq_phase_timer #(.TW(TW), .WW(WW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .len_i      (len),
    .strobe_i   (state_q == ST_STROBE),
    .wait_i     (mem_wait_i),
    .wait_max_i (cfg_wait_max_i),
    .last_o     (last),
    .cap_o      (cap)
  );

  asq_lane_path #(.BUS_W(BUS_W), .LANE_W(LANE_W)) i_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wload_i  (wdata_pop_o),
    .wdata_i  (wdata_i),
    .lane_i   (beat_q[LANE_W-1:0]),
    .dout_o   (mem_dout_o),
    .cap_i    (cap_rd),
    .din_i    (mem_din_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_cs_o     = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign mem_oe_o     = (state_q == ST_STROBE) && !wr_q;
  assign mem_we_o     = (state_q == ST_STROBE) && wr_q;
  assign mem_addr_o   = {base_q, 2'b00} + (ADDR_W'(beat_q) << AOFF);
  assign timeout_o    = to_q;
  assign acc_cycles_o = cyc_q;

  // R2: handshake closes the door until the request completes
  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R9: bus address and data held from setup through hold
  a_r9_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE || state_q == ST_HOLD) |-> ($stable(mem_addr_o) && $stable(mem_dout_o)));
  // R7: timeout only rises after a cycle with wait still asserted
  a_r7_timeout_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(mem_wait_i));
  // R10: request length stays within the worst case the timing fields allow
  a_r10_cycle_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cycles_o <= CNT_W'(MAX_CYC));
endmodule

// File: tb/test_async_mem_seq.sv
`timescale 1ns/1ps
module test_async_mem_seq;
  localparam int AW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       req_write = 1'b0;
  logic [AW-3:0] req_waddr = '0;
  logic [3:0] req_words = '0;
  logic [3:0] cfg_s = 4'd1, cfg_t = 4'd2, cfg_h = 4'd1, cfg_u = 4'd2;
  logic [7:0] cfg_m = 8'd8;
  logic [7:0] wait_len = '0;
  logic       req_valid [2];
  logic [31:0] wsrc [16];

  logic        ready_w [2];
  logic        to_w [2];
  logic        cs_w [2];
  logic        rv_w [2];
  logic [15:0] cyc_w [2];
  logic [15:0] nacc_w [2];
  logic [15:0] stbc_w [2];
  logic [15:0] csc_w [2];
  logic [7:0]  npop_w [2];
  logic [7:0]  nrd_w [2];

  int n_cmp = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 2; g++) begin : g_dut
    localparam int BW = 8 << g;
    logic [BW-1:0] dout, din;
    logic [AW-1:0] maddr;
    logic          cs, oe, we, wt, pop, rv, to;
    logic [31:0]   rdata, wdata;
    logic [15:0]   cyc, nacc, stbc, csc;
    logic [7:0]    npop, nrd, srun;
    logic [4:0]    widx;
    logic          pstb;
    logic [7:0]    mem [0:(1<<AW)-1];
    logic [31:0]   rdw [16];

    assign wdata = wsrc[widx[3:0]];
    assign wt    = (oe || we) && (srun < wait_len);

    always_comb begin
      din = '0;
      for (int b = 0; b < BW/8; b++) din[b*8 +: 8] = mem[maddr + AW'(b)];
    end

    async_mem_seq #(.ADDR_W(AW), .BUS_W(BW)) i_async_mem_seq (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid[g]), .req_ready_o(ready_w[g]),
      .req_write_i(req_write), .req_waddr_i(req_waddr), .req_words_i(req_words),
      .cfg_setup_i(cfg_s), .cfg_strobe_i(cfg_t), .cfg_hold_i(cfg_h),
      .cfg_turn_i(cfg_u), .cfg_wait_max_i(cfg_m),
      .wdata_i(wdata), .wdata_pop_o(pop), .rdata_o(rdata), .rvalid_o(rv),
      .mem_addr_o(maddr), .mem_cs_o(cs), .mem_oe_o(oe), .mem_we_o(we),
      .mem_dout_o(dout), .mem_din_i(din), .mem_wait_i(wt),
      .timeout_o(to), .acc_cycles_o(cyc)
    );

    always @(posedge clk) begin
      if (we) for (int b = 0; b < BW/8; b++) mem[maddr + AW'(b)] <= dout[b*8 +: 8];
      if (clr) begin
        widx <= '0; nacc <= '0; stbc <= '0; csc <= '0; npop <= '0; nrd <= '0;
      end else begin
        if (pop) begin widx <= widx + 5'd1; npop <= npop + 8'd1; end
        if ((oe || we) && !pstb) nacc <= nacc + 16'd1;
        if (oe || we) stbc <= stbc + 16'd1;
        if (cs) csc <= csc + 16'd1;
        if (rv) begin rdw[nrd[3:0]] <= rdata; nrd <= nrd + 8'd1; end
      end
      srun <= (oe || we) ? srun + 8'd1 : 8'd0;
      pstb <= oe || we;
    end

    assign to_w[g] = to;   assign cs_w[g] = cs;     assign rv_w[g] = rv;
    assign cyc_w[g] = cyc; assign nacc_w[g] = nacc; assign stbc_w[g] = stbc;
    assign csc_w[g] = csc; assign npop_w[g] = npop; assign nrd_w[g] = nrd;
  end

  function automatic logic [31:0] mem_word(input int sel, input int a);
    logic [31:0] w;
    for (int b = 0; b < 4; b++)
      w[b*8 +: 8] = (sel == 0) ? g_dut[0].mem[a+b] : g_dut[1].mem[a+b];
    return w;
  endfunction

  function automatic logic [31:0] rd_word(input int sel, input int i);
    return (sel == 0) ? g_dut[0].rdw[i] : g_dut[1].rdw[i];
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // runs one request to completion, returns busy cycles seen at the ports
  task automatic run_req(input int sel, input logic wr, input int waddr, input int wm1,
                         output int busy);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    req_write = wr; req_waddr = (AW-2)'(waddr); req_words = 4'(wm1);
    req_valid[sel] = 1'b1;
    @(posedge clk); #1 req_valid[sel] = 1'b0;
    busy = 0;
    @(negedge clk);
    while (!ready_w[sel]) begin
      busy++;
      @(negedge clk);
    end
  endtask

  // common per-access checks: n accesses, total strobe extension ext, turnaround flag
  task automatic chk_shape(input int sel, input int n, input int ext, input bit turn, input int busy);
    int acc = cfg_s + cfg_t + cfg_h + 3;
    int exp_busy = n * acc + ext + (turn ? cfg_u + 1 : 0);
    chk("R3 access count", nacc_w[sel], n);
    chk("R4 strobe cycles", stbc_w[sel], n * (cfg_t + 1) + ext);
    chk("R4 chip select cycles", csc_w[sel], n * acc + ext);
    chk("R5 busy cycles incl turnaround", busy, exp_busy);
    chk("R10 cycle counter total", cyc_w[sel], exp_busy);
    chk("R2 ready back after request", ready_w[sel], 1);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk("R1 ready after reset", ready_w[s], 1);
      chk("R1 cs after reset", cs_w[s], 0);
      chk("R1 rvalid after reset", rv_w[s], 0);
      chk("R1 timeout after reset", to_w[s], 0);
      chk("R1 counter after reset", cyc_w[s], 0);
    end
  endtask

  task automatic t_write8_two();
    int busy;
    wsrc[0] = 32'h44332211; wsrc[1] = 32'h88776655;
    run_req(0, 1'b1, 4, 1, busy);
    chk_shape(0, 8, 0, 1'b1, busy);
    chk("R9 write words popped", npop_w[0], 2);
    chk("R9 word0 in memory", mem_word(0, 16), 32'h44332211);
    chk("R9 word1 in memory", mem_word(0, 20), 32'h88776655);
    chk("R7 no timeout without wait", to_w[0], 0);
  endtask

  task automatic t_read8_back();
    int busy;
    run_req(0, 1'b0, 4, 1, busy);
    chk_shape(0, 8, 0, 1'b1, busy);
    chk("R8 read words delivered", nrd_w[0], 2);
    chk("R8 read word0 little-endian", rd_word(0, 0), 32'h44332211);
    chk("R8 read word1 little-endian", rd_word(0, 1), 32'h88776655);
    run_req(0, 1'b0, 5, 0, busy);
    chk_shape(0, 4, 0, 1'b0, busy);
    chk("R3 address start of single word", rd_word(0, 0), 32'h88776655);
  endtask

  task automatic t_write16_three();
    int busy;
    wsrc[0] = 32'hA1B2C3D4; wsrc[1] = 32'h0F1E2D3C; wsrc[2] = 32'h55AA33CC;
    run_req(1, 1'b1, 16, 2, busy);
    chk_shape(1, 6, 0, 1'b1, busy);
    chk("R9 halfword write words popped", npop_w[1], 3);
    chk("R3 halfword word0", mem_word(1, 64), 32'hA1B2C3D4);
    chk("R3 halfword word1", mem_word(1, 68), 32'h0F1E2D3C);
    chk("R3 halfword word2", mem_word(1, 72), 32'h55AA33CC);
  endtask

  task automatic t_wait_stretch();
    int busy;
    wait_len = 8'd5; cfg_m = 8'd8;
    run_req(1, 1'b0, 17, 0, busy);
    chk_shape(1, 2, 6, 1'b1, busy);
    chk("R6 stretched read data", rd_word(1, 0), 32'h0F1E2D3C);
    chk("R6 no timeout below cap", to_w[1], 0);
  endtask

  task automatic t_wait_cap();
    int busy;
    wait_len = 8'd200; cfg_m = 8'd3;
    run_req(1, 1'b0, 18, 0, busy);
    chk_shape(1, 2, 6, 1'b0, busy);
    chk("R7 timeout set at cap", to_w[1], 1);
    chk("R8 data sampled at capped strobe", rd_word(1, 0), 32'h55AA33CC);
    repeat (4) @(negedge clk);
    chk("R7 timeout sticky while idle", to_w[1], 1);
    chk("R10 counter holds while idle", cyc_w[1], 20);
    wait_len = 8'd0;
    run_req(1, 1'b0, 16, 0, busy);
    chk_shape(1, 2, 0, 1'b0, busy);
    chk("R7 timeout cleared by next request", to_w[1], 0);
  endtask

  task automatic t_long8();
    int busy;
    cfg_s = 4'd0; cfg_t = 4'd0; cfg_h = 4'd0;
    for (int i = 0; i < 16; i++) wsrc[i] = 32'h10203040 + 32'(i) * 32'h01030507;
    run_req(0, 1'b1, 64, 15, busy);
    chk_shape(0, 64, 0, 1'b1, busy);
    chk("R9 sixteen words popped", npop_w[0], 16);
    for (int i = 0; i < 16; i++)
      chk("R9 long write word", mem_word(0, 256 + 4*i), wsrc[i]);
    run_req(0, 1'b0, 64, 15, busy);
    chk_shape(0, 64, 0, 1'b1, busy);
    chk("R8 sixteen words read", nrd_w[0], 16);
    for (int i = 0; i < 16; i++)
      chk("R8 long read word", rd_word(0, i), wsrc[i]);
  endtask

  initial begin
    req_valid[0] = 1'b0; req_valid[1] = 1'b0;
    for (int i = 0; i < 16; i++) wsrc[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write8_two();
    t_read8_back();
    t_write16_three();
    t_wait_stretch();
    t_wait_cap();
    t_long8();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL R2 watchdog: actual no completion expected request done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule